// File: doc/BRIEF.md
# Configurable PAL output macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives eight product terms from the logic array and ORs them. An XOR sets the polarity of the sum. A three-bit configuration then routes the result. It can go through a D flip-flop to the pin, or straight to the pin. The configuration also lets the cell give up its output and act as an input. The same configuration picks the source of the tri-state enable and the signal fed back into the array.

The configuration is made of two device-wide mode bits (`sg0`, `sg1`) and one cell-local mode bit (`sl0`). A further local bit (`sl1`) sets the polarity. In the two I/O modes the lowest product term, `pterm[0]`, is taken out of the sum and drives the output enable. The flip-flop is cleared by reset. A preload strobe can force a chosen value into it for testing. The parameter `END_CELL` marks the cells at the two ends of the device, where the feedback selection is steered differently. Configurations that match no defined mode silence the cell and raise a flag.

Top module: `pal_macrocell`

## Requirements
- R1: Registered mode ({sg0,sg1,sl0}=3'b010): the flip-flop captures (OR of all eight terms) XOR sl1 on each rising edge of `clk`. The flip-flop captures its XOR input on every edge in every mode, and in the two I/O modes that input is the seven-term sum. In registered mode `pin_out` and `fb_out` both show the flip-flop value and `pin_oe` follows `oe_glob`.
- R2: Registered-device I/O mode (3'b011): `pin_out` = (OR of pterm[7:1]) XOR sl1, `pin_oe` = pterm[0] and `fb_out` = `pad_in`.
- R3: Dedicated output mode (3'b100): `pin_out` = (OR of all eight terms) XOR sl1 and `pin_oe` = 1. In a normal cell `fb_out` = `pad_in`.
- R4: Dedicated input mode (3'b101): `pin_oe` = 0, `pin_out` = 0 and `fb_out` = `adj_in`.
- R5: Combinatorial I/O mode (3'b111): `pin_out` = (OR of pterm[7:1]) XOR sl1 and `pin_oe` = pterm[0]. In a normal cell `fb_out` = `pad_in`.
- R6: With sl1=0 the output is the sum itself (active high). With sl1=1 it is the inverted sum. This holds in the combinatorial modes and for the value the flip-flop captures.
- R7: When `pre_en` is 1 at a rising edge, the flip-flop loads `pre_d` instead of its normal input.
- R8: While `rst_n` is 0 the flip-flop reads 0 at once, and a preload is ignored. After `rst_n` rises, the flip-flop stays cleared until the second rising edge.
- R9: In an end cell (END_CELL=1), `fb_out` is 0 in dedicated output mode and is `adj_in` in combinatorial I/O mode. All other modes behave as in a normal cell.
- R10: The configurations 3'b000, 3'b001 and 3'b110 drive `pin_out`, `pin_oe` and `fb_out` to 0 and set `cfg_bad` to 1. Every defined mode keeps `cfg_bad` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global register clock, rising edge |
| rst_n | input | 1 | Power-up reset, active low, asserted asynchronously |
| pterm | input | NUM_TERMS | Product terms from the AND array |
| oe_glob | input | 1 | Global output enable used in registered mode, active high |
| pad_in | input | 1 | Value seen on the cell's own pin |
| adj_in | input | 1 | Value seen on the adjacent pin |
| sg0 | input | 1 | Device-wide mode bit 0 |
| sg1 | input | 1 | Device-wide mode bit 1 |
| sl0 | input | 1 | Cell-local mode bit |
| sl1 | input | 1 | Cell-local polarity bit, 1 inverts |
| pre_en | input | 1 | Preload strobe, sampled on the clock edge |
| pre_d | input | 1 | Preload value |
| pin_out | output | 1 | Value driven towards the pin |
| pin_oe | output | 1 | Tri-state enable of the pin driver |
| fb_out | output | 1 | Feedback into the AND array |
| cfg_bad | output | 1 | Configuration matches no defined mode |

## Verification
The assertions take the configuration bits and all other inputs as stable and free of unknowns across each clock edge. The preload properties also expect `pre_en` to be driven at every edge once reset is released. The stimulus changes inputs only on the falling edge and sets every input on every call. Before any check depends on the flip-flop, the stimulus leaves at least two idle cycles after each reset release. During those cycles the flip-flop value is not visible at any port.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  typedef enum logic [2:0] {
    CM_BAD,
    CM_REG,
    CM_CIO_R,
    CM_COUT,
    CM_DIN,
    CM_CIO
  } cell_mode_e;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import pal_mc_pkg::*;
(
  input  logic       sg0,
  input  logic       sg1,
  input  logic       sl0,
  output cell_mode_e mode
);
  always_comb begin
    case ({sg0, sg1, sl0})
      3'b010:  mode = CM_REG;
      3'b011:  mode = CM_CIO_R;
      3'b100:  mode = CM_COUT;
      3'b101:  mode = CM_DIN;
      3'b111:  mode = CM_CIO;
      default: mode = CM_BAD;
    endcase
  end
endmodule

// File: rtl/mc_sum.sv
module mc_sum #(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] pterm,
  input  logic                 use_all,
  input  logic                 sl1,
  output logic                 xr
);
  localparam int UPPER = NUM_TERMS - 1;
  logic sum;

  always_comb begin
    if (use_all) sum = |pterm;
    else         sum = |pterm[UPPER:1];
    xr = sum ^ sl1;
  end
endmodule

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sr;
  logic [STAGES-1:0] sr_nxt;

  always_comb sr_nxt = {sr[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end

  assign rst_sn = sr[STAGES-1];
endmodule

// File: rtl/mc_reg.sv
module mc_reg (
  input  logic clk,
  input  logic rst_sn,
  input  logic d,
  input  logic pre_en,
  input  logic pre_d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (pre_en) q_nxt = pre_d;
    else        q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) q <= 1'b0;
    else         q <= q_nxt;
  end

  assert_preload_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    pre_en |=> (q == $past(pre_d)));

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    !pre_en |=> (q == $past(d)));
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_mc_pkg::*;
#(
  parameter int NUM_TERMS   = 8,
  parameter bit END_CELL    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TERMS-1:0] pterm,
  input  logic                 oe_glob,
  input  logic                 pad_in,
  input  logic                 adj_in,
  input  logic                 sg0,
  input  logic                 sg1,
  input  logic                 sl0,
  input  logic                 sl1,
  input  logic                 pre_en,
  input  logic                 pre_d,
  output logic                 pin_out,
  output logic                 pin_oe,
  output logic                 fb_out,
  output logic                 cfg_bad
);
  cell_mode_e mode;
  logic       use_all;
  logic       xr;
  logic       q;
  logic       rst_sn;
  logic       fb_cout;
  logic       fb_cio;

  mc_decode u_dec (.sg0(sg0), .sg1(sg1), .sl0(sl0), .mode(mode));

  // the enable term leaves the sum only in the two I/O modes
  assign use_all = (mode != CM_CIO_R) && (mode != CM_CIO);

  mc_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
    .pterm(pterm), .use_all(use_all), .sl1(sl1), .xr(xr)
  );

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  mc_reg u_reg (
    .clk(clk), .rst_sn(rst_sn), .d(xr),
    .pre_en(pre_en), .pre_d(pre_d), .q(q)
  );

  // end cells steer their feedback select with the other global bit
  if (END_CELL) begin : g_end
    assign fb_cout = 1'b0;
    assign fb_cio  = adj_in;
  end else begin : g_mid
    assign fb_cout = pad_in;
    assign fb_cio  = pad_in;
  end

  always_comb begin
    pin_out = 1'b0;
    pin_oe  = 1'b0;
    fb_out  = 1'b0;
    cfg_bad = 1'b0;
    case (mode)
      CM_REG: begin
        pin_out = q;
        pin_oe  = oe_glob;
        fb_out  = q;
      end
      CM_CIO_R: begin
        pin_out = xr;
        pin_oe  = pterm[0];
        fb_out  = pad_in;
      end
      CM_COUT: begin
        pin_out = xr;
        pin_oe  = 1'b1;
        fb_out  = fb_cout;
      end
      CM_DIN: begin
        fb_out  = adj_in;
      end
      CM_CIO: begin
        pin_out = xr;
        pin_oe  = pterm[0];
        fb_out  = fb_cio;
      end
      default: cfg_bad = 1'b1;
    endcase
  end

  assert_bad_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> (!pin_oe && !fb_out && !pin_out));

  assert_reg_loop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_REG) |-> (pin_out == fb_out));

  assert_din_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_DIN) |-> (!pin_oe && !pin_out && !cfg_bad));

  assert_io_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == CM_CIO) || (mode == CM_CIO_R)) |-> (pin_oe == pterm[0]));
endmodule

// File: tb/test_pal_macrocell.sv
module test_pal_macrocell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pterm;
  logic       oe_glob, pad_in, adj_in, sg0, sg1, sl0, sl1, pre_en, pre_d;
  logic       m_out, m_oe, m_fb, m_bad;
  logic       e_out, e_oe, e_fb, e_bad;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic exp_q = 1'b0;
  logic [7:0] exp_q_items[$];
  string      tag_q[$];
  event       chk_ev;

  always #10 clk = ~clk;

  pal_macrocell #(.END_CELL(1'b0)) i_pal_macrocell (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_glob(oe_glob),
    .pad_in(pad_in), .adj_in(adj_in), .sg0(sg0), .sg1(sg1), .sl0(sl0),
    .sl1(sl1), .pre_en(pre_en), .pre_d(pre_d),
    .pin_out(m_out), .pin_oe(m_oe), .fb_out(m_fb), .cfg_bad(m_bad)
  );

  pal_macrocell #(.END_CELL(1'b1)) i_pal_macrocell_end (
    .clk(clk), .rst_n(rst_n), .pterm(pterm), .oe_glob(oe_glob),
    .pad_in(pad_in), .adj_in(adj_in), .sg0(sg0), .sg1(sg1), .sl0(sl0),
    .sl1(sl1), .pre_en(pre_en), .pre_d(pre_d),
    .pin_out(e_out), .pin_oe(e_oe), .fb_out(e_fb), .cfg_bad(e_bad)
  );

  // expected {pin_out, pin_oe, fb_out, cfg_bad} from the requirements
  function automatic logic [3:0] model(input logic end_c, input logic q);
    logic s8, s7;
    s8 = (|pterm) ^ sl1;
    s7 = (|pterm[7:1]) ^ sl1;
    case ({sg0, sg1, sl0})
      3'b010:  model = {q, oe_glob, q, 1'b0};
      3'b011:  model = {s7, pterm[0], pad_in, 1'b0};
      3'b100:  model = {s8, 1'b1, end_c ? 1'b0 : pad_in, 1'b0};
      3'b101:  model = {1'b0, 1'b0, adj_in, 1'b0};
      3'b111:  model = {s7, pterm[0], end_c ? adj_in : pad_in, 1'b0};
      default: model = 4'b0001;
    endcase
  endfunction

  function automatic logic next_d();
    if ({sg0, sg1, sl0} == 3'b011 || {sg0, sg1, sl0} == 3'b111)
      next_d = (|pterm[7:1]) ^ sl1;
    else
      next_d = (|pterm) ^ sl1;
  endfunction

  task automatic push(input string tag);
    exp_q_items.push_back({model(1'b0, exp_q), model(1'b1, exp_q)});
    tag_q.push_back(tag);
    ->chk_ev;
  endtask

  task automatic apply(input string tag, input logic [2:0] cfg, input logic pol,
                       input logic [7:0] pt, input logic oe_g, input logic pad,
                       input logic adj, input logic pen, input logic pd);
    @(negedge clk);
    {sg0, sg1, sl0} = cfg;
    sl1 = pol; pterm = pt; oe_glob = oe_g; pad_in = pad; adj_in = adj;
    pre_en = pen; pre_d = pd;
    @(posedge clk);
    if (!rst_n)    exp_q = 1'b0;
    else if (pen)  exp_q = pd;
    else           exp_q = next_d();
    #5;
    push(tag);
  endtask

  task automatic idle3();
    for (int i = 0; i < 3; i++)
      apply("R8 idle after release", 3'b101, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: pop each expected item and compare both cells
  initial begin
    forever begin
      logic [7:0] e;
      string t;
      @(chk_ev);
      e = exp_q_items.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({m_out, m_oe, m_fb, m_bad} !== e[7:4] ||
          {e_out, e_oe, e_fb, e_bad} !== e[3:0]) begin
        bad++;
        $display("FAIL %s: actual mid=%b end=%b expected mid=%b end=%b",
                 t, {m_out, m_oe, m_fb, m_bad}, {e_out, e_oe, e_fb, e_bad},
                 e[7:4], e[3:0]);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {sg0, sg1, sl0} = 3'b010;
    sl1 = 1'b0; pterm = 8'h00; oe_glob = 1'b1; pad_in = 1'b0; adj_in = 1'b0;
    pre_en = 1'b0; pre_d = 1'b0;
    // R8: in reset, registered output reads 0 even with a preload and a true sum
    apply("R8 reset clears", 3'b010, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    apply("R8 reset holds", 3'b010, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle3();
    // R1 registered capture, R6 polarity
    apply("R1 capture high", 3'b010, 1'b0, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R1 capture low",  3'b010, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R6 register inverted", 3'b010, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R1 oe follows global", 3'b010, 1'b1, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7 preload wins over capture
    apply("R7 preload 0", 3'b010, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    apply("R7 preload 1", 3'b010, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R2 registered-device I/O
    apply("R2 upper terms", 3'b011, 1'b0, 8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R2 term0 excluded", 3'b011, 1'b0, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R2 R6 inverted", 3'b011, 1'b1, 8'h40, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3 dedicated output, R9 end cell has no feedback
    apply("R3 R9 term0 counts", 3'b100, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R3 R6 inverted zero", 3'b100, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R3 all zero", 3'b100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R4 dedicated input
    apply("R4 adjacent 1", 3'b101, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R4 adjacent 0", 3'b101, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5 combinatorial I/O, R9 end cell feeds back adjacent
    apply("R5 R9 pad vs adj", 3'b111, 1'b0, 8'h21, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R5 R9 enable off", 3'b111, 1'b0, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R5 term0 only", 3'b111, 1'b1, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R10 undefined configurations
    apply("R10 cfg 000", 3'b000, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R10 cfg 001", 3'b001, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R10 cfg 110", 3'b110, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R8 asynchronous clear while the register holds 1
    apply("R7 preload before reset", 3'b010, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    exp_q = 1'b0;
    push("R8 async clear");
    apply("R8 preload ignored in reset", 3'b010, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle3();
    apply("R1 capture after reset", 3'b010, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule